// File: doc/BRIEF.md
# Coalescing Store Buffer for a Write-Through Cache

This block sits between a write-through data cache and main memory. Every store that the processor issues goes into the buffer and not straight to memory. The buffer keeps up to four pending blocks. Each block is an aligned group of four 64-bit words and has its own per-word valid mask. A store to a block that already has a pending entry is folded into that entry. Memory therefore sees fewer, wider transfers.

Entries leave in the order they were opened. The oldest entry is offered on a valid/ready memory port as one block write: a block-aligned address, all four data words and the word mask. A store flagged as targeting an uncached or I/O region is never combined with anything. When no entry can take an incoming store, the processor is held off with a stall signal until space frees up.

Top module: `coalesce_wbuf`

## Requirements
- R1: After reset the buffer is empty: `memValid` is low and `wrStall` is low while no store is presented.
- R2: A store to an empty buffer appears on the memory port on the next cycle. `memAddr` is the store address with bits [4:0] cleared, and `memMask` has only bit i set, where i is address bits [4:3]. Word i sits in `memData` bits [64*i+63 : 64*i]. Address bits [2:0] are ignored.
- R3: A store whose block matches a pending entry that is not currently offered to memory and not flagged uncached is merged into that entry. Its mask bit is set and its data is placed in that word. No new entry is opened.
- R4: A merged store to a word that is already valid replaces that word's data.
- R5: Entries are offered to memory in the order they were opened. While `memValid` is high and `memReady` is low, `memAddr`, `memMask` and `memData` hold steady. An entry leaves on a cycle where both are high.
- R6: The entry being offered to memory accepts no merges. A store to its block opens a new entry.
- R7: A store with `wrNoMerge` high always opens its own entry. An entry opened that way never takes a later merge.
- R8: `wrStall` is high exactly when `wrValid` is high, four entries are pending, and the store cannot merge. A stalled store has no effect on the buffer.
- R9: A store that can merge is accepted without stall even when all four entries are pending.
- R10: When the buffer is not full, a store that opens an entry and a drain of the oldest entry in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Store request present |
| wrAddr | input | 32 | Store byte address |
| wrData | input | 64 | Store data word |
| wrNoMerge | input | 1 | Store targets an uncached/I/O region; never merge |
| wrStall | output | 1 | Store cannot be accepted this cycle |
| memValid | output | 1 | A block write is offered to memory |
| memReady | input | 1 | Memory accepts the offered block |
| memAddr | output | 32 | Block-aligned byte address of the offered block |
| memData | output | 256 | Four data words of the offered block, word 0 lowest |
| memMask | output | 4 | Per-word valid mask of the offered block |

## Verification
The hardest state to reach is a full buffer that still accepts stores. It has to hold a mix of ordinary and uncached entries for the same block, and the head entry's block must match the incoming store. To build it, the bench holds `memReady` low while it opens entries to a handful of blocks. It then offers stores that must merge, stores that must stall, and uncached stores to a block that is already pending. Sweeps over three blocks, four word slots, both merge flags and patterned memory readiness are then checked cycle by cycle against an arithmetic queue model in the bench.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  parameter int unsigned EntryCnt = 4;
  parameter int unsigned BlkWords = 4;
  localparam int unsigned PtrW = (EntryCnt > 1) ? $clog2(EntryCnt) : 1;

  typedef logic [PtrW-1:0] ptr_t;

  typedef struct packed {
    logic alloc;
    logic merge;
    ptr_t wrIdx;
    logic pop;
    ptr_t headIdx;
  } strobe_t;
endpackage

// File: rtl/cwb_ctrl.sv
module cwb_ctrl
  import cwb_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrValid,
  input  logic                wrNoMerge,
  input  logic                memReady,
  input  logic [EntryCnt-1:0] blkMatch,
  output strobe_t             strb,
  output logic                wrStall,
  output logic                memValid
);
  localparam int unsigned CntW = $clog2(EntryCnt + 1);

  ptr_t                headPtr;
  ptr_t                tailPtr;
  logic [CntW-1:0]     fill;
  logic [EntryCnt-1:0] occ;
  logic [EntryCnt-1:0] mergeable;
  logic [EntryCnt-1:0] allocBit;
  logic [EntryCnt-1:0] popBit;
  ptr_t                hitIdx;
  logic                canMerge;
  logic                full;

  function automatic ptr_t bump(input ptr_t p);
    return (p == ptr_t'(EntryCnt - 1)) ? '0 : p + 1'b1;
  endfunction

  // candidate entries: same block, occupied, not the one on the memory port
  always_comb begin
    mergeable = blkMatch & occ;
    mergeable[headPtr] = 1'b0;
    hitIdx = '0;
    for (int i = EntryCnt - 1; i >= 0; i--) begin
      if (mergeable[i]) hitIdx = ptr_t'(i);
    end
  end

  assign canMerge = wrValid && !wrNoMerge && (|mergeable);
  assign full     = (fill == CntW'(EntryCnt));
  assign memValid = (fill != '0);
  assign wrStall  = wrValid && !canMerge && full;

  assign strb.merge   = canMerge;
  assign strb.alloc   = wrValid && !canMerge && !full;
  assign strb.wrIdx   = canMerge ? hitIdx : tailPtr;
  assign strb.pop     = memValid && memReady;
  assign strb.headIdx = headPtr;

  assign allocBit = strb.alloc ? (EntryCnt'(1) << tailPtr) : '0;
  assign popBit   = strb.pop   ? (EntryCnt'(1) << headPtr) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      fill    <= '0;
      occ     <= '0;
    end else begin
      if (strb.alloc) tailPtr <= bump(tailPtr);
      if (strb.pop)   headPtr <= bump(headPtr);
      occ <= (occ | allocBit) & ~popBit;
      case ({strb.alloc, strb.pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // R3
  merge_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(mergeable));

  // R8
  stall_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStall |-> ($countones(occ) == EntryCnt));

  // R8
  occ_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(occ) == int'(fill));

  // R5
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && headPtr == $past(headPtr)));
endmodule

// File: rtl/cwb_data.sv
module cwb_data
  import cwb_pkg::*;
#(
  parameter int unsigned AddrW = 32,
  parameter int unsigned DataW = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strb,
  input  logic [AddrW-1:0]          wrAddr,
  input  logic [DataW-1:0]          wrData,
  input  logic                      wrNoMerge,
  output logic [EntryCnt-1:0]       blkMatch,
  output logic [AddrW-1:0]          memAddr,
  output logic [BlkWords*DataW-1:0] memData,
  output logic [BlkWords-1:0]       memMask
);
  localparam int unsigned OffW  = $clog2(DataW / 8);
  localparam int unsigned WordW = $clog2(BlkWords);
  localparam int unsigned BlkW  = AddrW - OffW - WordW;

  logic [BlkW-1:0]     entBlk  [EntryCnt];
  logic [DataW-1:0]    entWord [EntryCnt][BlkWords];
  logic [BlkWords-1:0] entMask [EntryCnt];
  logic [EntryCnt-1:0] entIo;

  logic [BlkW-1:0]  inBlk;
  logic [WordW-1:0] inWord;

  assign inBlk  = wrAddr[AddrW-1 -: BlkW];
  assign inWord = wrAddr[OffW +: WordW];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < EntryCnt; i++) begin
        entBlk[i]  <= '0;
        entMask[i] <= '0;
        for (int w = 0; w < BlkWords; w++) entWord[i][w] <= '0;
      end
      entIo <= '0;
    end else if (strb.alloc || strb.merge) begin
      entWord[strb.wrIdx][inWord] <= wrData;
      if (strb.alloc) begin
        entBlk[strb.wrIdx]  <= inBlk;
        entIo[strb.wrIdx]   <= wrNoMerge;
        entMask[strb.wrIdx] <= BlkWords'(1) << inWord;
      end else begin
        entMask[strb.wrIdx][inWord] <= 1'b1;
      end
    end
  end

  generate
    for (genvar i = 0; i < EntryCnt; i++) begin : g_match
      assign blkMatch[i] = (entBlk[i] == inBlk) && !entIo[i];
    end
    for (genvar w = 0; w < BlkWords; w++) begin : g_word
      assign memData[w*DataW +: DataW] = entWord[strb.headIdx][w];
    end
  endgenerate

  assign memAddr = {entBlk[strb.headIdx], {(OffW + WordW){1'b0}}};
  assign memMask = entMask[strb.headIdx];

  // R7
  io_merge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.merge |-> !entIo[strb.wrIdx]);
endmodule

// File: rtl/coalesce_wbuf.sv
module coalesce_wbuf
  import cwb_pkg::*;
#(
  parameter int unsigned AddrW = 32,
  parameter int unsigned DataW = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrValid,
  input  logic [AddrW-1:0]          wrAddr,
  input  logic [DataW-1:0]          wrData,
  input  logic                      wrNoMerge,
  output logic                      wrStall,
  output logic                      memValid,
  input  logic                      memReady,
  output logic [AddrW-1:0]          memAddr,
  output logic [BlkWords*DataW-1:0] memData,
  output logic [BlkWords-1:0]       memMask
);
  strobe_t             strb;
  logic [EntryCnt-1:0] blkMatch;

  cwb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrValid  (wrValid),
    .wrNoMerge(wrNoMerge),
    .memReady (memReady),
    .blkMatch (blkMatch),
    .strb     (strb),
    .wrStall  (wrStall),
    .memValid (memValid)
  );

  cwb_data #(.AddrW(AddrW), .DataW(DataW)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .wrNoMerge(wrNoMerge),
    .blkMatch (blkMatch),
    .memAddr  (memAddr),
    .memData  (memData),
    .memMask  (memMask)
  );

  // R5
  head_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=>
      ($stable(memAddr) && $stable(memMask) && $stable(memData)));

  // R2
  mask_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memMask != '0));
endmodule

// File: tb/sim_coalesce_wbuf.sv
`timescale 1ns/1ps
module sim_coalesce_wbuf;
  localparam int Base = 32'h0000_4000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrValid = 1'b0;
  logic [31:0]  wrAddr = '0;
  logic [63:0]  wrData = '0;
  logic         wrNoMerge = 1'b0;
  logic         wrStall;
  logic         memValid;
  logic         memReady = 1'b0;
  logic [31:0]  memAddr;
  logic [255:0] memData;
  logic [3:0]   memMask;

  int nChecks = 0;
  int nErrors = 0;
  int serial  = 0;
  bit done    = 0;

  // bench model of pending entries, index 0 is the oldest
  int          mN = 0;
  int          mBlk  [4];
  bit          mIo   [4];
  logic [3:0]  mMask [4];
  logic [63:0] mData [4][4];

  always #5 clk = ~clk;

  coalesce_wbuf u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .wrNoMerge(wrNoMerge), .wrStall(wrStall),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
    .memData(memData), .memMask(memMask)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare before posedge, update model after it
  task automatic step(input bit v, input int blk, input int wd, input bit io,
                      input bit rdy, input string req);
    int mIdx;
    bit expStall;
    bit hadHead;
    logic [63:0] d;
    @(negedge clk);
    serial++;
    d = {16'hC0DE, 16'(serial), 16'(blk), 16'(wd)};
    wrValid   = v;
    wrAddr    = 32'(Base + blk * 32 + wd * 8 + (serial % 8));
    wrData    = d;
    wrNoMerge = io;
    memReady  = rdy;
    #1;
    mIdx = -1;
    if (v && !io) begin
      for (int i = 1; i < mN; i++)
        if (mIdx < 0 && mBlk[i] == blk && !mIo[i]) mIdx = i;
    end
    expStall = v && (mIdx < 0) && (mN == 4);
    check(wrStall == expStall, req, "wrStall", 64'(wrStall), 64'(expStall));
    check(memValid == (mN > 0), req, "memValid", 64'(memValid), 64'(mN > 0));
    if (mN > 0) begin
      check(memAddr == 32'(Base + mBlk[0] * 32), req, "memAddr",
            64'(memAddr), 64'(Base + mBlk[0] * 32));
      check(memMask == mMask[0], req, "memMask", 64'(memMask), 64'(mMask[0]));
      for (int w = 0; w < 4; w++)
        if (mMask[0][w])
          check(memData[w*64 +: 64] == mData[0][w], req, "memData",
                memData[w*64 +: 64], mData[0][w]);
    end
    hadHead = (mN > 0);
    @(posedge clk);
    if (v && !expStall) begin
      if (mIdx >= 0) begin
        mData[mIdx][wd] = d;
        mMask[mIdx][wd] = 1'b1;
      end else begin
        mBlk[mN]      = blk;
        mIo[mN]       = io;
        mMask[mN]     = 4'(1 << wd);
        mData[mN][wd] = d;
        mN++;
      end
    end
    if (hadHead && rdy) begin
      for (int i = 0; i < 3; i++) begin
        mBlk[i]  = mBlk[i+1];
        mIo[i]   = mIo[i+1];
        mMask[i] = mMask[i+1];
        for (int w = 0; w < 4; w++) mData[i][w] = mData[i+1][w];
      end
      mN--;
    end
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < 12; k++) step(0, 0, 0, 0, 1, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    step(0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 1, "R1");

    // R2: single store, held offer, then drained
    step(1, 5, 2, 0, 0, "R2");
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, "R5");
    drain("R2");

    // fill with merges while memory is not ready
    step(1, 1, 0, 0, 0, "R2");   // head entry for block 1
    step(1, 1, 1, 0, 0, "R6");   // head cannot merge: new entry
    step(1, 1, 3, 0, 0, "R3");   // merge into second entry
    step(1, 1, 1, 0, 0, "R4");   // overwrite word 1
    step(1, 2, 0, 0, 0, "R3");
    step(1, 3, 2, 0, 0, "R3");   // now full
    step(1, 4, 0, 0, 0, "R8");   // cannot merge: stall
    step(1, 4, 0, 0, 0, "R8");
    step(1, 1, 2, 0, 0, "R9");   // merge while full
    step(1, 2, 1, 1, 0, "R8");   // uncached, full: stall
    step(1, 4, 0, 0, 1, "R8");   // stalled while head leaves
    step(1, 4, 0, 0, 0, "R10");  // accepted now
    drain("R5");

    // uncached entries never merge
    step(1, 6, 0, 0, 0, "R7");
    step(1, 6, 1, 1, 0, "R7");
    step(1, 6, 2, 0, 0, "R7");
    step(1, 6, 3, 0, 0, "R7");
    step(1, 6, 3, 1, 0, "R7");
    drain("R7");

    // R10: open and drain in one cycle
    step(1, 7, 0, 0, 0, "R10");
    step(1, 8, 1, 0, 1, "R10");
    step(1, 8, 2, 0, 1, "R10");
    drain("R10");

    // sweeps over block, word, flag and readiness patterns
    for (int pass = 0; pass < 3; pass++) begin
      for (int b = 0; b < 3; b++)
        for (int w = 0; w < 4; w++)
          for (int f = 0; f < 2; f++) begin
            int k = b * 8 + w * 2 + f;
            bit rdy = (pass == 0) ? ((k * 7 + w) % 5 < 2)
                    : (pass == 1) ? (k % 6 == 0) : (k % 2 == 1);
            bit io  = (pass == 2) ? f[0] : (f == 1 && (k % 3 == 0));
            step(((k + pass) % 7) != 6, (b + w * pass) % 3, (w + f + pass) % 4,
                 io, rdy, "R3");
          end
      drain("R5");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end
endmodule